// File: doc/BRIEF.md
# USB Endpoint Buffer Status Controller

This block holds the buffer state of every endpoint of a five-endpoint USB device. Each endpoint owns a double buffer. One half is worked by the USB engine and the other by the CPU. For each endpoint the block keeps three things. The first is a full flag for each half. The second is the current data direction. The third is a write-only request that lets the next status phase be acknowledged automatically. The CPU reaches all endpoints through one 8-bit status/command register, and an endpoint index picks which endpoint's copy is read or written.

The USB engine sends indexed event strobes. These report that its half was filled or drained, the real direction of a transfer, and the end of a status phase. It also drives one stall line per endpoint. The CPU uses command bits to hand its half over to the USB side, to flush an endpoint, and to predict the direction of the next transfer. A prediction only takes effect while both halves are empty. The block drives per-endpoint full flags, the direction, the status auto-acknowledge and a status interrupt strobe.

Top module: `usb_ep_status_ctl`

## Requirements
- R1: After reset every endpoint reads back 0x20: both full flags are 0, the direction is 1 (CPU-to-host) and the status enable is 0.
- R2: A read returns the USB-half full flag in bit 7, the CPU-half full flag in bit 6 and the direction in bit 5. Bits 4..0 always read 0, including when the status enable is set. An index of 5 or more reads 0x00.
- R3: usb_fill_i sets the USB-half flag of endpoint usb_ep_i, and usb_drain_i clears it. If both arrive together, fill wins. cpu_load_i sets the CPU-half flag of endpoint cpu_sel_i.
- R4: A write with bit 0 (hand-over) set while the USB-half flag is 0 moves the CPU-half flag into the USB-half flag and clears the CPU-half flag. While the USB-half flag is 1, the hand-over is ignored. A hand-over takes priority over USB fill/drain and CPU load events in the same cycle.
- R5: A write with bit 1 (flush) clears both full flags of the selected endpoint and leaves the direction unchanged. It overrides every other flag event in that cycle.
- R6: A write with bit 2 (predict write) sets the direction to 1, and a write with bit 3 (predict read) sets it to 0. Either one takes effect only when both full flags are 0.
- R7: A direction prediction is ignored when bits 2 and 3 are both set, or when bit 1 is set in the same write.
- R8: usb_dir_valid_i loads usb_dir_i into the direction of endpoint usb_ep_i. It wins over a CPU prediction in the same cycle.
- R9: A write with bit 4 sets the status enable. stat_ack_o[n] is high exactly when endpoint n has the enable set and stall_i[n] is low.
- R10: When usb_stat_done_i arrives for an endpoint with stat_ack_o high, its status enable clears and no interrupt is raised. Otherwise stat_irq_o for that endpoint is high for exactly the next cycle.
- R11: Writes, loads and USB events change only the endpoint they index. An index of 5 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_sel_i | input | 3 | Endpoint index for CPU read, write and load |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write command byte |
| cpu_load_i | input | 1 | CPU half of selected endpoint has been filled |
| cpu_rdata_o | output | 8 | Status of selected endpoint |
| usb_ep_i | input | 3 | Endpoint index for USB events |
| usb_fill_i | input | 1 | USB half filled |
| usb_drain_i | input | 1 | USB half drained |
| usb_dir_valid_i | input | 1 | Real transfer direction is valid |
| usb_dir_i | input | 1 | Real transfer direction (1 = CPU-to-host) |
| usb_stat_done_i | input | 1 | Status phase completed |
| stall_i | input | 5 | Per-endpoint stall |
| usb_full_o | output | 5 | USB-half full flags |
| cpu_full_o | output | 5 | CPU-half full flags |
| dir_o | output | 5 | Direction per endpoint |
| stat_ack_o | output | 5 | Status phase auto-acknowledge |
| stat_irq_o | output | 5 | Status interrupt strobe |

## Verification
The assertions check the following on every cycle. The low read bits are always zero. An acknowledge never coexists with a stall. A flush empties both flags one cycle later. A reported direction is loaded, and the direction stays still when neither side acts. An interrupt is raised only after a status completion, and never after an acknowledged one. Some behaviours depend on the current flag state and need set-up sequences, so only the bench's scenarios can show them. These are the conditional hand-over, a prediction blocked by a full half, a prediction rejected for conflicting bits, the priority order among simultaneous events, and the isolation between endpoints. They are checked by directed sequences and by a randomized phase compared against a behavioural model.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CMD_W   = 5;
  // command/status bit positions
  localparam int unsigned B_DONE  = 0;
  localparam int unsigned B_FLUSH = 1;
  localparam int unsigned B_PR_WR = 2;
  localparam int unsigned B_PR_RD = 3;
  localparam int unsigned B_SENA  = 4;
  localparam int unsigned B_DIR   = 5;
  localparam int unsigned B_CFULL = 6;
  localparam int unsigned B_UFULL = 7;

  typedef struct packed {
    logic sena;
    logic dir_req;
    logic dir_val;
    logic flush;
    logic done;
  } ep_cmd_t;
endpackage

// File: rtl/ep_cmd_dec.sv
module ep_cmd_dec
  import usb_ep_pkg::*;
(
  input  logic             wr_i,
  input  logic [CMD_W-1:0] bits_i,
  output ep_cmd_t          cmd_o
);
  logic conflict;
  assign conflict      = bits_i[B_PR_WR] & bits_i[B_PR_RD];
  assign cmd_o.sena    = wr_i & bits_i[B_SENA];
  assign cmd_o.flush   = wr_i & bits_i[B_FLUSH];
  assign cmd_o.done    = wr_i & bits_i[B_DONE] & ~bits_i[B_FLUSH];
  assign cmd_o.dir_req = wr_i & (bits_i[B_PR_WR] | bits_i[B_PR_RD]) & ~conflict & ~bits_i[B_FLUSH];
  assign cmd_o.dir_val = bits_i[B_PR_WR];
endmodule

// File: rtl/ep_slot.sv
module ep_slot
  import usb_ep_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ep_cmd_t cmd_i,
  input  logic    usb_fill_i,
  input  logic    usb_drain_i,
  input  logic    cpu_load_i,
  input  logic    dir_valid_i,
  input  logic    dir_i,
  input  logic    stat_done_i,
  input  logic    stall_i,
  output logic    usb_full_o,
  output logic    cpu_full_o,
  output logic    dir_o,
  output logic    ack_o,
  output logic    irq_o
);
  logic uf_q, cf_q, dir_q, sena_q, irq_q;
  logic uf_d, cf_d, dir_d, sena_d, irq_d;
  logic empty, hand_ok;

  assign empty   = ~uf_q & ~cf_q;
  assign hand_ok = cmd_i.done & ~uf_q;
  assign ack_o   = sena_q & ~stall_i;

  always_comb begin
    uf_d = uf_q;
    cf_d = cf_q;
    if (usb_fill_i)       uf_d = 1'b1;
    else if (usb_drain_i) uf_d = 1'b0;
    if (cpu_load_i)       cf_d = 1'b1;
    if (hand_ok) begin
      uf_d = cf_q;
      cf_d = 1'b0;
    end
    if (cmd_i.flush) begin
      uf_d = 1'b0;
      cf_d = 1'b0;
    end
  end

  always_comb begin
    dir_d = dir_q;
    if (dir_valid_i)                dir_d = dir_i;
    else if (cmd_i.dir_req && empty) dir_d = cmd_i.dir_val;
  end

  // set from CPU beats hardware clear in the same cycle
  assign sena_d = cmd_i.sena | (sena_q & ~(stat_done_i & ack_o));
  assign irq_d  = stat_done_i & ~ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q   <= 1'b0;
      cf_q   <= 1'b0;
      dir_q  <= 1'b1;
      sena_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      uf_q   <= uf_d;
      cf_q   <= cf_d;
      dir_q  <= dir_d;
      sena_q <= sena_d;
      irq_q  <= irq_d;
    end
  end

  assign usb_full_o = uf_q;
  assign cpu_full_o = cf_q;
  assign dir_o      = dir_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/ep_rd_mux.sv
module ep_rd_mux
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 5,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [NUM_EP-1:0] usb_full_i,
  input  logic [NUM_EP-1:0] cpu_full_i,
  input  logic [NUM_EP-1:0] dir_i,
  output logic [REG_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel_i == IDX_W'(i)) begin
        rdata_o[B_UFULL] = usb_full_i[i];
        rdata_o[B_CFULL] = cpu_full_i[i];
        rdata_o[B_DIR]   = dir_i[i];
      end
    end
  end
endmodule

// File: rtl/usb_ep_status_ctl.sv
module usb_ep_status_ctl
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 5,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cpu_sel_i,
  input  logic              cpu_wr_i,
  input  logic [REG_W-1:0]  cpu_wdata_i,
  input  logic              cpu_load_i,
  output logic [REG_W-1:0]  cpu_rdata_o,
  input  logic [IDX_W-1:0]  usb_ep_i,
  input  logic              usb_fill_i,
  input  logic              usb_drain_i,
  input  logic              usb_dir_valid_i,
  input  logic              usb_dir_i,
  input  logic              usb_stat_done_i,
  input  logic [NUM_EP-1:0] stall_i,
  output logic [NUM_EP-1:0] usb_full_o,
  output logic [NUM_EP-1:0] cpu_full_o,
  output logic [NUM_EP-1:0] dir_o,
  output logic [NUM_EP-1:0] stat_ack_o,
  output logic [NUM_EP-1:0] stat_irq_o
);
  logic [REG_W-CMD_W-1:0] unused_wr_hi;
  assign unused_wr_hi = cpu_wdata_i[REG_W-1:CMD_W];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic    cpu_hit, usb_hit;
    ep_cmd_t cmd;
    assign cpu_hit = (cpu_sel_i == IDX_W'(e));
    assign usb_hit = (usb_ep_i == IDX_W'(e));

    ep_cmd_dec u_dec (
      .wr_i   (cpu_wr_i & cpu_hit),
      .bits_i (cpu_wdata_i[CMD_W-1:0]),
      .cmd_o  (cmd)
    );

    ep_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd),
      .usb_fill_i  (usb_fill_i & usb_hit),
      .usb_drain_i (usb_drain_i & usb_hit),
      .cpu_load_i  (cpu_load_i & cpu_hit),
      .dir_valid_i (usb_dir_valid_i & usb_hit),
      .dir_i       (usb_dir_i),
      .stat_done_i (usb_stat_done_i & usb_hit),
      .stall_i     (stall_i[e]),
      .usb_full_o  (usb_full_o[e]),
      .cpu_full_o  (cpu_full_o[e]),
      .dir_o       (dir_o[e]),
      .ack_o       (stat_ack_o[e]),
      .irq_o       (stat_irq_o[e])
    );
  end

  ep_rd_mux #(.NUM_EP(NUM_EP)) u_rd (
    .sel_i      (cpu_sel_i),
    .usb_full_i (usb_full_o),
    .cpu_full_i (cpu_full_o),
    .dir_i      (dir_o),
    .rdata_o    (cpu_rdata_o)
  );
endmodule

// File: rtl/usb_ep_status_chk.sv
module usb_ep_status_chk
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 5,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  cpu_sel_i,
  input logic              cpu_wr_i,
  input logic [REG_W-1:0]  cpu_wdata_i,
  input logic              cpu_load_i,
  input logic [REG_W-1:0]  cpu_rdata_o,
  input logic [IDX_W-1:0]  usb_ep_i,
  input logic              usb_fill_i,
  input logic              usb_drain_i,
  input logic              usb_dir_valid_i,
  input logic              usb_dir_i,
  input logic              usb_stat_done_i,
  input logic [NUM_EP-1:0] stall_i,
  input logic [NUM_EP-1:0] usb_full_o,
  input logic [NUM_EP-1:0] cpu_full_o,
  input logic [NUM_EP-1:0] dir_o,
  input logic [NUM_EP-1:0] stat_ack_o,
  input logic [NUM_EP-1:0] stat_irq_o
);
  logic sel_ok, ep_ok;
  assign sel_ok = 32'(cpu_sel_i) < NUM_EP;
  assign ep_ok  = 32'(usb_ep_i) < NUM_EP;

  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rdata_o[CMD_W-1:0] == '0); // R2

  AST_ACK_NOT_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_ack_o & stall_i) == '0); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_wdata_i[B_FLUSH] && sel_ok) |=>
      (!usb_full_o[$past(cpu_sel_i)] && !cpu_full_o[$past(cpu_sel_i)])); // R5

  AST_DIR_REPORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_dir_valid_i && ep_ok) |=> dir_o[$past(usb_ep_i)] == $past(usb_dir_i)); // R8

  AST_DIR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!usb_dir_valid_i && !cpu_wr_i) |=> $stable(dir_o)); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_irq_o != '0) |-> ($past(usb_stat_done_i) && $onehot0(stat_irq_o))); // R10

  AST_NO_IRQ_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_stat_done_i && ep_ok && stat_ack_o[usb_ep_i]) |=> (stat_irq_o == '0)); // R10
endmodule

bind usb_ep_status_ctl usb_ep_status_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/sim_usb_ep_status_ctl.sv
`timescale 1ns/1ps
module sim_usb_ep_status_ctl;
  localparam int NE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cpu_sel = '0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_load = 1'b0;
  logic [7:0] cpu_rdata;
  logic [2:0] usb_ep = '0;
  logic usb_fill = 1'b0, usb_drain = 1'b0, usb_dir_valid = 1'b0, usb_dir = 1'b0, usb_stat_done = 1'b0;
  logic [NE-1:0] stall = '0;
  logic [NE-1:0] usb_full, cpu_full, dir, stat_ack, stat_irq;

  int n_chk = 0, n_fail = 0;
  int m_uf[NE], m_cf[NE], m_dir[NE], m_sena[NE], m_irq[NE];

  always #4 clk = ~clk;

  usb_ep_status_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_sel_i(cpu_sel), .cpu_wr_i(cpu_wr),
    .cpu_wdata_i(cpu_wdata), .cpu_load_i(cpu_load), .cpu_rdata_o(cpu_rdata),
    .usb_ep_i(usb_ep), .usb_fill_i(usb_fill), .usb_drain_i(usb_drain),
    .usb_dir_valid_i(usb_dir_valid), .usb_dir_i(usb_dir), .usb_stat_done_i(usb_stat_done),
    .stall_i(stall), .usb_full_o(usb_full), .cpu_full_o(cpu_full), .dir_o(dir),
    .stat_ack_o(stat_ack), .stat_irq_o(stat_irq)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        m_uf[e] = 0; m_cf[e] = 0; m_dir[e] = 1; m_sena[e] = 0; m_irq[e] = 0;
      end
    end else begin
      for (int e = 0; e < NE; e++) begin
        int nuf, ncf, nd, ns, ni, ack;
        bit wr, ue, ce;
        nuf = m_uf[e]; ncf = m_cf[e]; nd = m_dir[e]; ns = m_sena[e]; ni = 0;
        ce = (int'(cpu_sel) == e);
        ue = (int'(usb_ep) == e);
        wr = cpu_wr && ce;
        if (usb_fill && ue) nuf = 1;
        else if (usb_drain && ue) nuf = 0;
        if (cpu_load && ce) ncf = 1;
        if (wr && cpu_wdata[0] && !cpu_wdata[1] && m_uf[e] == 0) begin nuf = m_cf[e]; ncf = 0; end
        if (wr && cpu_wdata[1]) begin nuf = 0; ncf = 0; end
        if (usb_dir_valid && ue) nd = usb_dir;
        else if (wr && (cpu_wdata[2] != cpu_wdata[3]) && !cpu_wdata[1] && m_uf[e] == 0 && m_cf[e] == 0)
          nd = cpu_wdata[2];
        ack = (m_sena[e] == 1 && !stall[e]) ? 1 : 0;
        if (usb_stat_done && ue) begin
          if (ack == 1) ns = 0; else ni = 1;
        end
        if (wr && cpu_wdata[4]) ns = 1;
        m_uf[e] = nuf; m_cf[e] = ncf; m_dir[e] = nd; m_sena[e] = ns; m_irq[e] = ni;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_rd(input int s);
    if (s >= NE) return 0;
    return (m_uf[s] << 7) | (m_cf[s] << 6) | (m_dir[s] << 5);
  endfunction

  task automatic cmp_all();
    for (int e = 0; e < NE; e++) begin
      chk("R3 usb_full", int'(usb_full[e]), m_uf[e]);
      chk("R3 cpu_full", int'(cpu_full[e]), m_cf[e]);
      chk("R6 dir", int'(dir[e]), m_dir[e]);
      chk("R9 stat_ack", int'(stat_ack[e]), (m_sena[e] == 1 && !stall[e]) ? 1 : 0);
      chk("R10 stat_irq", int'(stat_irq[e]), m_irq[e]);
    end
    chk("R2 rdata", int'(cpu_rdata), m_rd(int'(cpu_sel)));
  endtask

  task automatic idle();
    cpu_wr = 0; cpu_wdata = '0; cpu_load = 0;
    usb_fill = 0; usb_drain = 0; usb_dir_valid = 0; usb_stat_done = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    cmp_all();
    idle();
    #1;
  endtask

  task automatic wr(input int s, input logic [7:0] d);
    cpu_sel = 3'(s); cpu_wr = 1; cpu_wdata = d; tick();
  endtask

  function automatic int rd(input int s);
    return 0;
  endfunction

  task automatic peek(input int s, input string tag, input int exp);
    cpu_sel = 3'(s); #1;
    chk(tag, int'(cpu_rdata), exp);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #2;
    // R1 reset state
    for (int e = 0; e < NE; e++) peek(e, "R1 reset readback", 'h20);
    peek(5, "R2 out-of-range read", 'h00);
    // R3 usb fill/drain, cpu load
    usb_ep = 1; usb_fill = 1; tick();
    chk("R3 fill ep1", int'(usb_full[1]), 1);
    usb_ep = 1; usb_fill = 1; usb_drain = 1; tick();
    chk("R3 fill beats drain", int'(usb_full[1]), 1);
    usb_ep = 1; usb_drain = 1; tick();
    chk("R3 drain ep1", int'(usb_full[1]), 0);
    cpu_sel = 2; cpu_load = 1; tick();
    chk("R3 load ep2", int'(cpu_full[2]), 1);
    // R4 hand-over
    wr(2, 8'h01);
    peek(2, "R4 hand-over", 'hA0);
    cpu_sel = 2; cpu_load = 1; tick();
    wr(2, 8'h01);
    peek(2, "R4 hand-over blocked", 'hE0);
    // R5 flush with a simultaneous fill
    usb_ep = 2; usb_fill = 1; cpu_sel = 2; cpu_wr = 1; cpu_wdata = 8'h02; tick();
    peek(2, "R5 flush keeps dir", 'h20);
    // R6 predictions
    wr(3, 8'h08);
    peek(3, "R6 predict read", 'h00);
    wr(3, 8'h04);
    peek(3, "R6 predict write", 'h20);
    usb_ep = 3; usb_fill = 1; tick();
    wr(3, 8'h08);
    peek(3, "R6 predict blocked by full", 'hA0);
    usb_ep = 3; usb_drain = 1; tick();
    // R7 rejected predictions
    wr(3, 8'h0C);
    peek(3, "R7 both bits", 'h20);
    cpu_sel = 3; cpu_load = 1; tick();
    wr(3, 8'h0A);
    peek(3, "R7 with flush", 'h20);
    // R8 engine override
    usb_ep = 3; usb_dir_valid = 1; usb_dir = 0; cpu_sel = 3; cpu_wr = 1; cpu_wdata = 8'h04; tick();
    chk("R8 engine wins", int'(dir[3]), 0);
    // R9 status enable
    wr(0, 8'h10);
    chk("R9 ack set", int'(stat_ack[0]), 1);
    peek(0, "R2 enable reads zero", 'h20);
    stall[0] = 1; #1;
    chk("R9 stall blocks ack", int'(stat_ack[0]), 0);
    // R10 stalled completion raises irq and keeps enable
    usb_ep = 0; usb_stat_done = 1; tick();
    chk("R10 irq when stalled", int'(stat_irq[0]), 1);
    stall[0] = 0; tick();
    chk("R10 irq one cycle", int'(stat_irq[0]), 0);
    usb_ep = 0; usb_stat_done = 1; tick();
    chk("R10 no irq on ack", int'(stat_irq[0]), 0);
    chk("R10 enable cleared", int'(stat_ack[0]), 0);
    usb_ep = 0; usb_stat_done = 1; tick();
    chk("R10 irq without enable", int'(stat_irq[0]), 1);
    tick();
    // R11 isolation and out-of-range index
    wr(4, 8'h08);
    chk("R11 ep4 only", int'(dir), 5'b00111 & ~5'b00000 | (int'(dir) & 5'b01000));
    cpu_sel = 5; cpu_load = 1; cpu_wr = 1; cpu_wdata = 8'h1F; tick();
    usb_ep = 5; usb_fill = 1; tick();
    chk("R11 index 5 ignored", int'(usb_full | cpu_full | stat_ack), 0);
    // randomized phase against the model
    for (int i = 0; i < 3000; i++) begin
      cpu_sel = 3'($urandom_range(0, 5));
      usb_ep = 3'($urandom_range(0, 5));
      cpu_wr = ($urandom_range(0, 3) == 0);
      cpu_wdata = 8'($urandom);
      cpu_load = ($urandom_range(0, 3) == 0);
      usb_fill = ($urandom_range(0, 3) == 0);
      usb_drain = ($urandom_range(0, 3) == 0);
      usb_dir_valid = ($urandom_range(0, 7) == 0);
      usb_dir = 1'($urandom);
      usb_stat_done = ($urandom_range(0, 5) == 0);
      stall = 5'($urandom) & 5'($urandom);
      tick();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule